// File: doc/BRIEF.md
# Panel Video Input Conditioner

This block sits at the front of a flat-panel timing controller. It samples data enable, horizontal sync, vertical sync and RGB pixel data on the dot clock. Each sync gets its own polarity correction from a static strap. The result is a uniform stream for the downstream timing generators: the pixels always leave on a dual odd/even port, and both syncs are active high.

A strap selects the input format. In pair mode the source delivers an odd/even pixel pair on every clock. In single mode one pixel arrives per clock, and the block groups consecutive pixels into pairs. Whichever format is in use, the block counts the pixel pairs in each data-enable burst. It then sorts the line into a narrow class (the 1024-wide timing) or a wide class (the 1280-wide timing). It publishes a registered resolution flag, and a one-cycle strobe whenever that flag changes. Out-of-band lines are ignored, and a new decision waits for a frame boundary.

Top module: `pxl_ingress`

## Requirements
- R1: While `rst_n_i` is low and in the first cycle after it rises, `de_o`, `vs_o`, `hs_o`, `mode_stb_o` are 0 and `wide_o` equals the `RESET_WIDE` parameter (0 by default).
- R2: `vs_o` equals `vs_i` from one clock earlier when `vs_keep_i` is 1, and its inverse when `vs_keep_i` is 0.
- R3: `hs_o` follows `hs_i` with one clock of delay under the same rule, using `hs_keep_i`.
- R4: With `pair_mode_i` = 1, `de_o`, `odd_o` and `even_o` equal `de_i`, `pix_a_i` and `pix_b_i` from one clock earlier.
- R5: With `pair_mode_i` = 0, the first beat of a data-enable burst is the odd pixel and the next beat is the even pixel. The pair appears on `odd_o`/`even_o` one clock after the even beat, with `de_o` high for exactly that one clock. `de_o` is low in every other clock.
- R6: In single mode, a burst with an odd number of beats drops its final lone pixel. Pairing restarts with an odd pixel at the next burst.
- R7: A line's length is the number of pixel pairs in its burst: the number of beats in pair mode, or the number of completed pairs in single mode. The length is narrow if it lies within `NARROW_PAIRS ± BAND_TOL`, and wide if it lies within `WIDE_PAIRS ± BAND_TOL`, both bounds included.
- R8: `wide_o` (1 = wide timing, 0 = narrow timing) changes only on the clock after the corrected vertical sync rises. It takes the class of the most recent pair of back-to-back lines with the same class since the previous such rise.
- R9: A line outside both bands leaves `wide_o` unchanged and breaks the run of matching lines.
- R10: `mode_stb_o` is high for exactly the clocks in which `wide_o` shows a value different from the clock before. It does not pulse when the agreed class equals the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_n_i | input | 1 | Active-low initialization strap |
| pair_mode_i | input | 1 | 1 = odd/even pair per clock, 0 = one pixel per clock |
| vs_keep_i | input | 1 | 1 = vertical sync used as is, 0 = inverted |
| hs_keep_i | input | 1 | 1 = horizontal sync used as is, 0 = inverted |
| de_i | input | 1 | Data enable |
| vs_i | input | 1 | Vertical sync |
| hs_i | input | 1 | Horizontal sync |
| pix_a_i | input | 3*COLOR_W | Pixel (single) or odd pixel (pair mode), R in top bits |
| pix_b_i | input | 3*COLOR_W | Even pixel in pair mode, unused in single mode |
| de_o | output | 1 | Pair valid |
| vs_o | output | 1 | Corrected vertical sync, active high |
| hs_o | output | 1 | Corrected horizontal sync, active high |
| odd_o | output | 3*COLOR_W | Odd output pixel |
| even_o | output | 3*COLOR_W | Even output pixel |
| wide_o | output | 1 | Resolution flag |
| mode_stb_o | output | 1 | One-clock mode change strobe |

## Verification
The bench builds the block with NARROW_PAIRS = 24, WIDE_PAIRS = 30 and BAND_TOL = 1, keeping 8-bit colour. These short bands let full lines of every class, including each band's first and last length and the lengths just outside it, run in a few dozen clocks. They also let several whole frames in both input formats and all polarity settings fit in one run. The same reduction makes the run-length rule reachable: a lone in-band line, an out-of-band line between two matches, and a matching pair whose class equals the current mode.

// File: rtl/ingress_pkg.sv
package ingress_pkg;

   typedef enum logic [1:0] {
      BAND_NONE   = 2'd0,
      BAND_NARROW = 2'd1,
      BAND_WIDE   = 2'd2
   } band_e;

   localparam int SYNC_N  = 2;
   localparam int SYNC_HS = 0;
   localparam int SYNC_VS = 1;

endpackage

// File: rtl/ingress_sync_fix.sv
module ingress_sync_fix #(
   parameter int N = 2
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic [N-1:0] raw_i,
   input  logic [N-1:0] keep_i,
   output logic [N-1:0] fixed_o,
   output logic [N-1:0] fixed_q_o
);

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_lane
         logic lvl_q;
         assign fixed_o[gi] = raw_i[gi] ^ ~keep_i[gi];
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) lvl_q <= 1'b0;
            else          lvl_q <= fixed_o[gi];
         end
         assign fixed_q_o[gi] = lvl_q;
      end
   endgenerate

endmodule

// File: rtl/ingress_pairer.sv
module ingress_pairer #(
   parameter int PIX_W          = 24,
   parameter bit SUPPORT_SINGLE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             pair_mode_i,
   input  logic             de_i,
   input  logic [PIX_W-1:0] pix_a_i,
   input  logic [PIX_W-1:0] pix_b_i,
   output logic             de_o,
   output logic [PIX_W-1:0] odd_o,
   output logic [PIX_W-1:0] even_o,
   output logic             beat_o,
   output logic             line_end_o
);

   logic de_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) de_q <= 1'b0;
      else          de_q <= de_i;
   end

   assign line_end_o = de_q & ~de_i;

   generate
      if (SUPPORT_SINGLE) begin : g_both
         logic             half_q;
         logic [PIX_W-1:0] hold_q;

         assign beat_o = de_i & (pair_mode_i | half_q);

         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               half_q <= 1'b0;
               hold_q <= '0;
               de_o   <= 1'b0;
               odd_o  <= '0;
               even_o <= '0;
            end else if (pair_mode_i) begin
               half_q <= 1'b0;
               de_o   <= de_i;
               odd_o  <= pix_a_i;
               even_o <= pix_b_i;
            end else if (!de_i) begin
               half_q <= 1'b0;
               de_o   <= 1'b0;
            end else if (!half_q) begin
               half_q <= 1'b1;
               hold_q <= pix_a_i;
               de_o   <= 1'b0;
            end else begin
               half_q <= 1'b0;
               de_o   <= 1'b1;
               odd_o  <= hold_q;
               even_o <= pix_a_i;
            end
         end
      end else begin : g_pair_only
         assign beat_o = de_i;

         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               de_o   <= 1'b0;
               odd_o  <= '0;
               even_o <= '0;
            end else begin
               de_o   <= de_i;
               odd_o  <= pix_a_i;
               even_o <= pix_b_i;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ingress_classifier.sv
module ingress_classifier
   import ingress_pkg::*;
#(
   parameter int NARROW_PAIRS = 512,
   parameter int WIDE_PAIRS   = 640,
   parameter int BAND_TOL     = 8,
   parameter bit RESET_WIDE   = 1'b0
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic beat_i,
   input  logic line_end_i,
   input  logic frame_edge_i,
   output logic wide_o,
   output logic mode_stb_o
);

   localparam int CNT_MAX = WIDE_PAIRS + BAND_TOL + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] N_LO = CNT_W'(NARROW_PAIRS - BAND_TOL);
   localparam logic [CNT_W-1:0] N_HI = CNT_W'(NARROW_PAIRS + BAND_TOL);
   localparam logic [CNT_W-1:0] W_LO = CNT_W'(WIDE_PAIRS - BAND_TOL);
   localparam logic [CNT_W-1:0] W_HI = CNT_W'(WIDE_PAIRS + BAND_TOL);

   logic [CNT_W-1:0] cnt_q;
   band_e            band_now;
   band_e            last_q;
   band_e            pend_q;
   logic             pend_v_q;
   logic             wide_q;
   logic             stb_q;
   logic             pend_wide;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                         cnt_q <= '0;
      else if (line_end_i)                  cnt_q <= '0;
      else if (beat_i && cnt_q != CNT_TOP)  cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      if (cnt_q >= N_LO && cnt_q <= N_HI)      band_now = BAND_NARROW;
      else if (cnt_q >= W_LO && cnt_q <= W_HI) band_now = BAND_WIDE;
      else                                     band_now = BAND_NONE;
   end

   assign pend_wide = (pend_q == BAND_WIDE);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         last_q   <= BAND_NONE;
         pend_q   <= BAND_NONE;
         pend_v_q <= 1'b0;
         wide_q   <= RESET_WIDE;
         stb_q    <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (frame_edge_i) begin
            if (pend_v_q && pend_wide != wide_q) begin
               wide_q <= pend_wide;
               stb_q  <= 1'b1;
            end
            pend_v_q <= 1'b0;
            last_q   <= BAND_NONE;
         end else if (line_end_i) begin
            last_q <= band_now;
            if (band_now != BAND_NONE && band_now == last_q) begin
               pend_q   <= band_now;
               pend_v_q <= 1'b1;
            end
         end
      end
   end

   assign wide_o     = wide_q;
   assign mode_stb_o = stb_q;

endmodule

// File: rtl/pxl_ingress.sv
module pxl_ingress
   import ingress_pkg::*;
#(
   parameter int COLOR_W        = 8,
   parameter int NARROW_PAIRS   = 512,
   parameter int WIDE_PAIRS     = 640,
   parameter int BAND_TOL       = 8,
   parameter bit RESET_WIDE     = 1'b0,
   parameter bit SUPPORT_SINGLE = 1'b1,
   localparam int PIX_W         = 3 * COLOR_W
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             pair_mode_i,
   input  logic             vs_keep_i,
   input  logic             hs_keep_i,
   input  logic             de_i,
   input  logic             vs_i,
   input  logic             hs_i,
   input  logic [PIX_W-1:0] pix_a_i,
   input  logic [PIX_W-1:0] pix_b_i,
   output logic             de_o,
   output logic             vs_o,
   output logic             hs_o,
   output logic [PIX_W-1:0] odd_o,
   output logic [PIX_W-1:0] even_o,
   output logic             wide_o,
   output logic             mode_stb_o
);

   generate
      if (COLOR_W < 1) begin : g_bad_color
         $error("COLOR_W must be at least 1");
      end
      if (BAND_TOL < 0 || NARROW_PAIRS <= BAND_TOL) begin : g_bad_tol
         $error("BAND_TOL must be non-negative and below NARROW_PAIRS");
      end
      if (WIDE_PAIRS - BAND_TOL <= NARROW_PAIRS + BAND_TOL) begin : g_bad_bands
         $error("narrow and wide bands must not overlap");
      end
   endgenerate

   logic [SYNC_N-1:0] sync_raw;
   logic [SYNC_N-1:0] sync_keep;
   logic [SYNC_N-1:0] sync_fix;
   logic [SYNC_N-1:0] sync_fix_q;
   logic              beat;
   logic              line_end;
   logic              frame_edge;

   assign sync_raw[SYNC_HS]  = hs_i;
   assign sync_raw[SYNC_VS]  = vs_i;
   assign sync_keep[SYNC_HS] = hs_keep_i;
   assign sync_keep[SYNC_VS] = vs_keep_i;

   ingress_sync_fix #(.N(SYNC_N)) u_sync (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .raw_i     (sync_raw),
      .keep_i    (sync_keep),
      .fixed_o   (sync_fix),
      .fixed_q_o (sync_fix_q)
   );

   assign hs_o       = sync_fix_q[SYNC_HS];
   assign vs_o       = sync_fix_q[SYNC_VS];
   assign frame_edge = sync_fix[SYNC_VS] & ~sync_fix_q[SYNC_VS];

   ingress_pairer #(
      .PIX_W          (PIX_W),
      .SUPPORT_SINGLE (SUPPORT_SINGLE)
   ) u_pair (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .pair_mode_i (pair_mode_i),
      .de_i        (de_i),
      .pix_a_i     (pix_a_i),
      .pix_b_i     (pix_b_i),
      .de_o        (de_o),
      .odd_o       (odd_o),
      .even_o      (even_o),
      .beat_o      (beat),
      .line_end_o  (line_end)
   );

   ingress_classifier #(
      .NARROW_PAIRS (NARROW_PAIRS),
      .WIDE_PAIRS   (WIDE_PAIRS),
      .BAND_TOL     (BAND_TOL),
      .RESET_WIDE   (RESET_WIDE)
   ) u_class (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .beat_i       (beat),
      .line_end_i   (line_end),
      .frame_edge_i (frame_edge),
      .wide_o       (wide_o),
      .mode_stb_o   (mode_stb_o)
   );

endmodule

// File: rtl/ingress_chk.sv
module ingress_chk (
   input logic clk_i,
   input logic rst_n_i,
   input logic pair_mode_i,
   input logic vs_keep_i,
   input logic hs_keep_i,
   input logic de_i,
   input logic vs_i,
   input logic hs_i,
   input logic de_o,
   input logic vs_o,
   input logic hs_o,
   input logic wide_o,
   input logic mode_stb_o
);

   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) armed_q <= 1'b0;
      else          armed_q <= 1'b1;
   end

   // R2
   vs_follow_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      vs_o == ($past(vs_i) ^ ~$past(vs_keep_i)));

   // R3
   hs_follow_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      hs_o == ($past(hs_i) ^ ~$past(hs_keep_i)));

   // R4
   pair_de_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      $past(pair_mode_i) |-> de_o == $past(de_i));

   // R5
   single_gap_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      (!pair_mode_i && de_o) |=> (!de_o || pair_mode_i));

   // R8
   mode_at_frame_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      (wide_o != $past(wide_o)) |-> ($past(vs_i ^ ~vs_keep_i) && !$past(vs_o)));

   // R10
   stb_on_change_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      (wide_o != $past(wide_o)) |-> mode_stb_o);

   // R10
   stb_only_change_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      mode_stb_o |-> (wide_o != $past(wide_o)));

endmodule

bind pxl_ingress ingress_chk i_chk (
   .clk_i       (clk_i),
   .rst_n_i     (rst_n_i),
   .pair_mode_i (pair_mode_i),
   .vs_keep_i   (vs_keep_i),
   .hs_keep_i   (hs_keep_i),
   .de_i        (de_i),
   .vs_i        (vs_i),
   .hs_i        (hs_i),
   .de_o        (de_o),
   .vs_o        (vs_o),
   .hs_o        (hs_o),
   .wide_o      (wide_o),
   .mode_stb_o  (mode_stb_o)
);

// File: tb/test_pxl_ingress.sv
module test_pxl_ingress;

   localparam int CW = 8;
   localparam int PW = 3 * CW;
   localparam int NP = 24;
   localparam int WP = 30;
   localparam int TL = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pair_mode = 1'b1, vs_keep = 1'b1, hs_keep = 1'b1;
   logic de = 1'b0, vs = 1'b0, hs = 1'b0;
   logic [PW-1:0] pa = '0, pb = '0;
   logic de_o, vs_o, hs_o, wide_o, stb_o;
   logic [PW-1:0] odd_o, even_o;

   always #4 clk = ~clk;

   pxl_ingress #(
      .COLOR_W (CW), .NARROW_PAIRS (NP), .WIDE_PAIRS (WP), .BAND_TOL (TL)
   ) i_pxl_ingress (
      .clk_i (clk), .rst_n_i (rst_n), .pair_mode_i (pair_mode),
      .vs_keep_i (vs_keep), .hs_keep_i (hs_keep), .de_i (de), .vs_i (vs),
      .hs_i (hs), .pix_a_i (pa), .pix_b_i (pb), .de_o (de_o), .vs_o (vs_o),
      .hs_o (hs_o), .odd_o (odd_o), .even_o (even_o), .wide_o (wide_o),
      .mode_stb_o (stb_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // pending strap values, applied by the next step
   logic s_pm = 1'b1, s_vk = 1'b1, s_hk = 1'b1;

   // expected outputs and model state
   logic e_de = 0, e_vs = 0, e_hs = 0, e_wide = 0, e_stb = 0;
   logic [PW-1:0] e_odd = '0, e_even = '0;
   logic m_ph = 0, m_deq = 0, m_vsq = 0, m_pv = 0;
   logic [PW-1:0] m_hold = '0;
   int m_cnt = 0, m_last = 0, m_pend = 0;
   int pulses = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int band_of(input int n);
      if (n >= NP - TL && n <= NP + TL) return 1;
      if (n >= WP - TL && n <= WP + TL) return 2;
      return 0;
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // one clock: check outputs of the last edge, then drive and predict the next
   task automatic step(input logic d, input logic v_act, input logic h_act,
                       input logic [PW-1:0] a, input logic [PW-1:0] b);
      logic line_end, frame;
      @(negedge clk);
      chk(de_o === e_de, pair_mode ? "R4 de" : "R5 de", de_o, e_de);
      if (e_de) begin
         chk(odd_o === e_odd, pair_mode ? "R4 odd" : "R5 odd", odd_o, e_odd);
         chk(even_o === e_even, pair_mode ? "R4 even" : "R5 even", even_o, e_even);
      end
      chk(vs_o === e_vs, "R2 vsync", vs_o, e_vs);
      chk(hs_o === e_hs, "R3 hsync", hs_o, e_hs);
      chk(wide_o === e_wide, "R8 wide", wide_o, e_wide);
      chk(stb_o === e_stb, "R10 strobe", stb_o, e_stb);
      if (de_o === 1'b1) pulses++;
      pair_mode = s_pm; vs_keep = s_vk; hs_keep = s_hk;
      de = d; pa = a; pb = b;
      vs = v_act ^ ~s_vk;
      hs = h_act ^ ~s_hk;
      // prediction
      e_vs = v_act; e_hs = h_act; e_stb = 1'b0;
      line_end = !d && m_deq;
      frame = v_act && !m_vsq;
      if (frame) begin
         if (m_pv && ((m_pend == 2) != e_wide)) begin
            e_wide = (m_pend == 2);
            e_stb = 1'b1;
         end
         m_pv = 1'b0; m_last = 0;
      end else if (line_end) begin
         if (band_of(m_cnt) != 0 && band_of(m_cnt) == m_last) begin
            m_pend = band_of(m_cnt); m_pv = 1'b1;
         end
         m_last = band_of(m_cnt);
      end
      if (line_end) m_cnt = 0;
      else if (d && (s_pm || m_ph)) m_cnt++;
      if (s_pm) begin
         m_ph = 0; e_de = d; e_odd = a; e_even = b;
      end else if (!d) begin
         m_ph = 0; e_de = 0;
      end else if (!m_ph) begin
         m_ph = 1; m_hold = a; e_de = 0;
      end else begin
         m_ph = 0; e_de = 1; e_odd = m_hold; e_even = a;
      end
      m_deq = d; m_vsq = v_act;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0);
   endtask

   task automatic line(input int beats);
      pulses = 0;
      for (int i = 0; i < beats; i++) step(1'b1, 1'b0, 1'b0, PW'($urandom), PW'($urandom));
      step(1'b0, 1'b0, 1'b0, '0, '0);
      step(1'b0, 1'b0, 1'b1, '0, '0);
      step(1'b0, 1'b0, 1'b1, '0, '0);
      step(1'b0, 1'b0, 1'b0, '0, '0);
   endtask

   task automatic vsync();
      step(1'b0, 1'b0, 1'b0, '0, '0);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, '0, '0);
      idle(2);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(de_o === 1'b0 && vs_o === 1'b0 && hs_o === 1'b0, "R1 outputs in reset", {de_o, vs_o, hs_o}, 0);
      chk(wide_o === 1'b0 && stb_o === 1'b0, "R1 mode in reset", {wide_o, stb_o}, 0);
      rst_n = 1'b1;
      idle(3);

      // pair mode, plain polarity, two wide lines then frame
      line(30); line(30);
      chk(wide_o === 1'b0, "R8 no change before frame", wide_o, 0);
      vsync();
      chk(wide_o === 1'b1, "R8 wide after frame", wide_o, 1);

      // R9: out-of-band line breaks the run
      line(24); line(33); line(24);
      vsync();
      chk(wide_o === 1'b1, "R9 mode kept", wide_o, 1);

      // R7: narrow band edges
      line(23); line(25);
      vsync();
      chk(wide_o === 1'b0, "R7 narrow band edges", wide_o, 0);

      // R10: agreement equal to current mode gives no strobe (checked per step)
      line(24); line(24);
      vsync();
      chk(wide_o === 1'b0, "R10 same mode kept", wide_o, 0);

      // single mode, inverted syncs, odd beat count
      s_pm = 1'b0; s_vk = 1'b0; s_hk = 1'b0;
      idle(3);
      line(61);
      chk(pulses == 30, "R6 trailing pixel dropped", pulses, 30);
      line(60);
      chk(pulses == 30, "R5 pair count", pulses, 30);
      vsync();
      chk(wide_o === 1'b1, "R7 single-mode wide", wide_o, 1);

      // R7: just outside both bands
      line(44); line(64);
      vsync();
      chk(wide_o === 1'b1, "R9 outside bands", wide_o, 1);
      line(58); line(59);
      vsync();
      chk(wide_o === 1'b1, "R9 29 pairs is wide", wide_o, 1);
      line(50); line(51);
      vsync();
      chk(wide_o === 1'b0, "R7 single-mode narrow", wide_o, 0);

      // constrained random frames
      for (int f = 0; f < 12; f++) begin
         s_pm = 1'($urandom); s_vk = 1'($urandom); s_hk = 1'($urandom);
         idle(3);
         for (int l = 0; l < 2 + int'($urandom % 3); l++) begin
            int p;
            p = $urandom_range(21, 33);
            line(s_pm ? p : 2 * p + int'($urandom % 2));
         end
         vsync();
      end

      // R1: reset mid-run restores initial state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(de_o === 1'b0 && wide_o === 1'b0 && stb_o === 1'b0, "R1 re-reset", {de_o, wide_o, stb_o}, 0);
      summary();
   end

endmodule